// File: doc/BRIEF.md
# Page Map Address Translator

This block turns a virtual address into a physical address by looking up a page map held in on-chip flops, one entry per virtual page. The upper bits of the virtual address select an entry, and the lower bits are the byte offset within the page, which is carried unchanged. Each entry holds a resident flag, a modified flag and a physical page number. When the selected entry is resident, the block returns the physical page number placed above the offset. When it is not resident, the block reports a page fault that carries the virtual page number.

Requests use a valid/ready handshake and carry a store flag. A store that reaches a resident page marks that page as modified in hardware. A separate update port lets an external fault handler rewrite any entry. The handler uses it to install a freshly loaded page as resident and clean, and to drop residency on the page it evicted. The update port takes priority over requests in the same cycle.

Top module: `pmap_xlate`

## Requirements
- R1: For a resident page, `rsp_pa` equals the entry's physical page number shifted left by `OFF_W` bits, ORed with the low `OFF_W` bits of the request address, which pass through unchanged.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Exactly one of `rsp_valid` or `flt_valid` is 1 for the single cycle after an accepted request, and both are 0 in every other cycle.
- R3: A request to an entry whose resident flag is 0 raises `flt_valid` for one cycle with `flt_vpn` equal to the request's upper `VA_W-OFF_W` address bits. In that cycle `rsp_valid` is 0 and `rsp_pa` is 0.
- R4: A store (`req_wr`=1) to a resident page sets that entry's modified flag. `rsp_dirty` is 1 on that response and on every later hit to the same page, until the entry is rewritten.
- R5: A load (`req_wr`=0) leaves the modified flag unchanged, and `rsp_dirty` reports the flag's current value.
- R6: After reset, every entry is non-resident, so the first access to any page faults. After reset all outputs are 0 and `req_ready` is 1.
- R7: With `upd_en`=1, the entry at `upd_vpn` takes `upd_res`, `upd_dirty` and `upd_ppn` at the clock edge. Requests accepted after that edge see the new values, including a modified flag cleared to 0.
- R8: While `upd_en` is 1, `req_ready` is 0 and no request is accepted, so no response or fault follows that cycle.
- R9: When the update port clears an entry's resident flag, later accesses to that page fault again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_va | input | VA_W | Virtual address |
| req_wr | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Translation succeeded, one-cycle pulse |
| rsp_pa | output | PA_W | Physical address (0 unless rsp_valid) |
| rsp_dirty | output | 1 | Modified flag of the page after this access |
| flt_valid | output | 1 | Page fault, one-cycle pulse |
| flt_vpn | output | VA_W-OFF_W | Faulting virtual page number |
| upd_en | input | 1 | Rewrite one page map entry |
| upd_vpn | input | VA_W-OFF_W | Entry to rewrite |
| upd_res | input | 1 | New resident flag |
| upd_dirty | input | 1 | New modified flag |
| upd_ppn | input | PA_W-OFF_W | New physical page number |

## Verification
The properties assume that `req_va` and `req_wr` are stable whenever a request is accepted, and that the update port is used only between requests. A request offered while `upd_en` is high is simply not accepted. The bench drives every input on the falling edge and holds `req_valid` for one cycle at a time. It also raises `req_valid` together with `upd_en` once, to exercise the refusal. Expected addresses and flags come from a per-page arithmetic mapping and a shadow copy of the modified flags, both kept in the bench. The stimulus sweeps all pages of the default configuration with loads, stores, evictions and remaps.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
   // Outcome of an accepted translation request
   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_HIT   = 2'd1,
      PM_FAULT = 2'd2
   } pm_kind_e;
endpackage

// File: rtl/pmap_table.sv
module pmap_table #(
   parameter int VPN_W = 6,
   parameter int PPN_W = 4,
   localparam int ENTRIES = 1 << VPN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             rd_res,
   output logic             rd_dirty,
   output logic [PPN_W-1:0] rd_ppn,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic             wr_res,
   input  logic             wr_dirty,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             mark_en,
   input  logic [VPN_W-1:0] mark_vpn
);
   logic             res_q   [ENTRIES];
   logic             dirty_q [ENTRIES];
   logic [PPN_W-1:0] ppn_q   [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      logic wr_hit;
      logic mark_hit;
      assign wr_hit   = wr_en   && (wr_vpn   == VPN_W'(i));
      assign mark_hit = mark_en && (mark_vpn == VPN_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q[i]   <= 1'b0;
            dirty_q[i] <= 1'b0;
            ppn_q[i]   <= '0;
         end else if (wr_hit) begin
            res_q[i]   <= wr_res;
            dirty_q[i] <= wr_dirty;
            ppn_q[i]   <= wr_ppn;
         end else if (mark_hit) begin
            dirty_q[i] <= 1'b1;
         end
      end
   end

   assign rd_res   = res_q[rd_vpn];
   assign rd_dirty = dirty_q[rd_vpn];
   assign rd_ppn   = ppn_q[rd_vpn];
endmodule

// File: rtl/pmap_resp.sv
module pmap_resp #(
   parameter int OFF_W = 10,
   parameter int VPN_W = 6,
   parameter int PPN_W = 4,
   localparam int PA_W = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             ent_res,
   input  logic             ent_dirty,
   input  logic [PPN_W-1:0] ent_ppn,
   input  logic [VPN_W-1:0] vpn,
   input  logic [OFF_W-1:0] off,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_dirty,
   output logic             flt_valid,
   output logic [VPN_W-1:0] flt_vpn
);
   import pmap_pkg::*;

   pm_kind_e        kind;
   logic [PA_W-1:0] pa_next;

   always_comb begin
      if (!accept)      kind = PM_IDLE;
      else if (ent_res) kind = PM_HIT;
      else              kind = PM_FAULT;
   end

   assign pa_next = (PA_W'(ent_ppn) << OFF_W) | PA_W'(off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_dirty <= 1'b0;
         flt_valid <= 1'b0;
         flt_vpn   <= '0;
      end else begin
         rsp_valid <= (kind == PM_HIT);
         rsp_pa    <= (kind == PM_HIT) ? pa_next : '0;
         rsp_dirty <= (kind == PM_HIT) && ent_dirty;
         flt_valid <= (kind == PM_FAULT);
         flt_vpn   <= (kind == PM_FAULT) ? vpn : '0;
      end
   end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate #(
   parameter int VA_W  = 16,
   parameter int OFF_W = 10,
   parameter int PA_W  = 14,
   localparam int VPN_W = VA_W - OFF_W,
   localparam int PPN_W = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_wr,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_dirty,
   output logic             flt_valid,
   output logic [VPN_W-1:0] flt_vpn,
   input  logic             upd_en,
   input  logic [VPN_W-1:0] upd_vpn,
   input  logic             upd_res,
   input  logic             upd_dirty,
   input  logic [PPN_W-1:0] upd_ppn
);
   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off
      $error("pmap_xlate: OFF_W must lie between 1 and VA_W-1");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("pmap_xlate: PA_W must exceed OFF_W");
   end
   if (VPN_W > 12) begin : g_bad_vpn
      $error("pmap_xlate: page map limited to 4096 entries");
   end

   logic             accept;
   logic [VPN_W-1:0] vpn;
   logic [OFF_W-1:0] off;
   logic             ent_res;
   logic             ent_dirty;
   logic [PPN_W-1:0] ent_ppn;

   assign req_ready = !upd_en;
   assign accept    = req_valid && req_ready;
   assign vpn       = req_va[VA_W-1:OFF_W];
   assign off       = req_va[OFF_W-1:0];

   pmap_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_vpn   (vpn),
      .rd_res   (ent_res),
      .rd_dirty (ent_dirty),
      .rd_ppn   (ent_ppn),
      .wr_en    (upd_en),
      .wr_vpn   (upd_vpn),
      .wr_res   (upd_res),
      .wr_dirty (upd_dirty),
      .wr_ppn   (upd_ppn),
      .mark_en  (accept && req_wr && ent_res),
      .mark_vpn (vpn)
   );

   pmap_resp #(.OFF_W(OFF_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .ent_res   (ent_res),
      .ent_dirty (ent_dirty || req_wr),
      .ent_ppn   (ent_ppn),
      .vpn       (vpn),
      .off       (off),
      .rsp_valid (rsp_valid),
      .rsp_pa    (rsp_pa),
      .rsp_dirty (rsp_dirty),
      .flt_valid (flt_valid),
      .flt_vpn   (flt_vpn)
   );
endmodule

// File: rtl/pmap_xlate_chk.sv
module pmap_xlate_chk #(
   parameter int VA_W  = 16,
   parameter int OFF_W = 10,
   parameter int PA_W  = 14,
   localparam int VPN_W = VA_W - OFF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [VA_W-1:0]  req_va,
   input logic             req_wr,
   input logic             rsp_valid,
   input logic [PA_W-1:0]  rsp_pa,
   input logic             rsp_dirty,
   input logic             flt_valid,
   input logic [VPN_W-1:0] flt_vpn,
   input logic             upd_en
);
   // R2
   resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || flt_valid));

   // R2
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !(rsp_valid || flt_valid));

   // R2
   resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && flt_valid));

   // R1
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         (!rsp_valid || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

   // R3
   fault_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         (!flt_valid || flt_vpn == $past(req_va[VA_W-1:OFF_W])));

   // R3
   fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |-> (rsp_pa == '0));

   // R4
   store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_wr) |=> (!rsp_valid || rsp_dirty));

   // R8
   update_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> !(rsp_valid || flt_valid));
endmodule

bind pmap_xlate pmap_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_va    (req_va),
   .req_wr    (req_wr),
   .rsp_valid (rsp_valid),
   .rsp_pa    (rsp_pa),
   .rsp_dirty (rsp_dirty),
   .flt_valid (flt_valid),
   .flt_vpn   (flt_vpn),
   .upd_en    (upd_en)
);

// File: tb/tb_pmap_xlate.sv
module tb_pmap_xlate;
   localparam int VA_W  = 16;
   localparam int OFF_W = 10;
   localparam int PA_W  = 14;
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;
   localparam int PAGES = 1 << VPN_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [VA_W-1:0]  req_va = '0;
   logic             req_wr = 1'b0;
   logic             rsp_valid;
   logic [PA_W-1:0]  rsp_pa;
   logic             rsp_dirty;
   logic             flt_valid;
   logic [VPN_W-1:0] flt_vpn;
   logic             upd_en = 1'b0;
   logic [VPN_W-1:0] upd_vpn = '0;
   logic             upd_res = 1'b0;
   logic             upd_dirty = 1'b0;
   logic [PPN_W-1:0] upd_ppn = '0;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   bit  dirty_m [PAGES];

   always #10 clk = ~clk;

   pmap_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut (.*);

   function automatic logic [PPN_W-1:0] ppn_of(int v);
      return PPN_W'((v * 5 + 3) % (1 << PPN_W));
   endfunction

   function automatic logic [OFF_W-1:0] off_of(int v, int k);
      return OFF_W'((v * 37 + k * 311) % (1 << OFF_W));
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(int v, logic [OFF_W-1:0] off, bit wr);
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = {VPN_W'(v), off};
      req_wr    = wr;
      @(negedge clk);
      req_valid = 1'b0;
      req_wr    = 1'b0;
   endtask

   task automatic update(int v, bit res, bit dty, logic [PPN_W-1:0] ppn);
      @(negedge clk);
      upd_en    = 1'b1;
      upd_vpn   = VPN_W'(v);
      upd_res   = res;
      upd_dirty = dty;
      upd_ppn   = ppn;
      @(negedge clk);
      upd_en    = 1'b0;
   endtask

   task automatic expect_hit(string req, int v, logic [OFF_W-1:0] off, bit dty);
      logic [PA_W-1:0] exp_pa;
      exp_pa = (PA_W'(ppn_of(v)) << OFF_W) | PA_W'(off);
      chk(rsp_valid == 1'b1 && flt_valid == 1'b0, req, "hit flags",
          {rsp_valid, flt_valid}, 2'b10);
      chk(rsp_pa == exp_pa, req, "physical address", rsp_pa, exp_pa);
      chk(rsp_dirty == dty, req, "modified flag", rsp_dirty, dty);
   endtask

   task automatic expect_fault(string req, int v);
      chk(flt_valid == 1'b1 && rsp_valid == 1'b0, req, "fault flags",
          {flt_valid, rsp_valid}, 2'b10);
      chk(flt_vpn == VPN_W'(v), req, "fault page", flt_vpn, v);
      chk(rsp_pa == '0, req, "no address on fault", rsp_pa, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset state of outputs
      chk(rsp_valid == 0 && flt_valid == 0 && rsp_pa == 0 && flt_vpn == 0 && rsp_dirty == 0,
          "R6", "outputs after reset", {rsp_valid, flt_valid, rsp_dirty}, 0);
      chk(req_ready == 1'b1, "R6", "ready after reset", req_ready, 1);

      // R6, R3: every page faults after reset
      for (int v = 0; v < PAGES; v++) begin
         send(v, off_of(v, 0), v[0]);
         expect_fault("R3", v);
      end
      // R2: one-cycle pulse
      @(negedge clk);
      chk(flt_valid == 0 && rsp_valid == 0, "R2", "pulse ends", {flt_valid, rsp_valid}, 0);

      // R8: update wins over a simultaneous request
      @(negedge clk);
      upd_en = 1'b1; upd_vpn = '0; upd_res = 1'b1; upd_dirty = 1'b0; upd_ppn = ppn_of(0);
      req_valid = 1'b1; req_va = '0; req_wr = 1'b1;
      #1;
      chk(req_ready == 1'b0, "R8", "ready during update", req_ready, 0);
      @(negedge clk);
      upd_en = 1'b0; req_valid = 1'b0; req_wr = 1'b0;
      chk(rsp_valid == 0 && flt_valid == 0, "R8", "no response to refused request",
          {rsp_valid, flt_valid}, 0);
      // the refused store must not have marked page 0
      send(0, 10'h005, 1'b0);
      expect_hit("R8", 0, 10'h005, 1'b0);

      // R7: install every page, resident and clean
      for (int v = 0; v < PAGES; v++) begin
         update(v, 1'b1, 1'b0, ppn_of(v));
         dirty_m[v] = 1'b0;
      end

      // R1, R5: loads of every page at two offsets
      for (int v = 0; v < PAGES; v++) begin
         for (int k = 1; k < 3; k++) begin
            send(v, off_of(v, k), 1'b0);
            expect_hit("R1", v, off_of(v, k), 1'b0);
         end
      end
      // R1: offset extremes
      send(PAGES - 1, '1, 1'b0);
      expect_hit("R1", PAGES - 1, '1, 1'b0);
      send(1, '0, 1'b0);
      expect_hit("R1", 1, '0, 1'b0);

      // R4: stores to every third page
      for (int v = 0; v < PAGES; v += 3) begin
         send(v, off_of(v, 4), 1'b1);
         dirty_m[v] = 1'b1;
         expect_hit("R4", v, off_of(v, 4), 1'b1);
      end
      // R5, R4: loads report the modified flags
      for (int v = 0; v < PAGES; v++) begin
         send(v, off_of(v, 5), 1'b0);
         expect_hit("R5", v, off_of(v, 5), dirty_m[v]);
      end

      // R9: evict page 3, which then faults
      update(3, 1'b0, 1'b0, ppn_of(3));
      send(3, 10'h123, 1'b0);
      expect_fault("R9", 3);
      send(3, 10'h124, 1'b1);
      expect_fault("R9", 3);
      // R7: reinstall clean, flag must read 0
      update(3, 1'b1, 1'b0, ppn_of(3));
      send(3, 10'h3ff, 1'b0);
      expect_hit("R7", 3, 10'h3ff, 1'b0);
      // R7: neighbour unaffected
      send(6, 10'h001, 1'b0);
      expect_hit("R7", 6, 10'h001, 1'b1);
      // R2: back-to-back requests
      @(negedge clk);
      req_valid = 1'b1; req_va = {VPN_W'(1), 10'h010}; req_wr = 1'b0;
      @(negedge clk);
      expect_hit("R2", 1, 10'h010, 1'b0);
      req_va = {VPN_W'(3), 10'h020}; req_wr = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_wr = 1'b0;
      expect_hit("R2", 3, 10'h020, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule